// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte addresses. The lower address is the index address. The address above it is the data address. All configuration registers stay hidden until the host writes a two-byte unlock key to the index address. A single lock byte hides them again. While the port is unlocked, a byte written to the index address selects a register number. Each later data access reads or writes that register.

Register numbers below 0x30 are global and shared by every function. Register numbers from 0x30 upward are banked: the value held in the device-select register chooses which logical device they belong to. Each logical device has an activate bit and a window of private byte registers. The block drives one activate line per device and the shared pin-function byte. It also drives a watchdog-routing flag that is decoded from that byte. Every accepted data write is presented on a simple write bus, so the function blocks behind the port can follow the configuration.

Top module: `keyed_cfg_port`

## Requirements
- R1: The port unlocks only after two index-address writes of 0x87 with no other index write between them. Data-address writes that fall between the two keys do not break the sequence. `cfg_unlocked` goes high in the cycle after the second key is clocked in.
- R2: An index write of any value other than 0x87, made while the port is locked, restarts the key sequence. For example, the sequence 0x87, 0x55, 0x87 leaves the port locked.
- R3: An index write of 0xAA while unlocked locks the port and leaves the index latch unchanged, so register 0xAA cannot be selected. While locked, data and index writes change no register: the index latch, the device select, the pin-function byte, the activate bits and the private registers all hold their values.
- R4: While the port is locked, a read of either address returns 0xFF and `bus_we` stays low.
- R5: While the port is unlocked, an index write other than 0xAA stores the register number. A read of the index address returns that number. A data access targets the register last selected.
- R6: Register 0x07 holds the logical-device number as a full byte and reads back as written. Register 0x07 is global (not banked).
- R7: Register 0x30 is the activate register of the selected device. Bit 0 drives `dev_active[n]` for device n. The register reads back as {7'b0, bit0}.
- R8: Register 0x2C is a global pin-function byte that reads back as written and appears on `pin_func`. `wdog_route` is 1 exactly when bit 4 is 1 and bit 5 is 0.
- R9: Each implemented device (0 to NUM_DEV-1) has its own private byte registers at 0xE0–0xF4. These registers are readable and writable, and a write to one device does not affect any other device.
- R10: Unimplemented registers read 0x00 and ignore writes. These are: registers below 0x30 other than 0x07 and 0x2C, registers 0x31–0xDF, registers 0xF5–0xFF, and every banked register when the device number is NUM_DEV or above.
- R11: After reset the port is locked, the device number is 0, all activate bits are clear, and the pin-function byte and all private registers are 0.
- R12: Each data write while unlocked raises `bus_we` in the same cycle. In that cycle `bus_dev` carries the device number, `bus_reg` the selected index and `bus_wdata` the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one byte per cycle |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 1 | 0 = index address, 1 = data address |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Read byte (combinational, 0 when not reading) |
| cfg_unlocked | output | 1 | Configuration mode is open |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| pin_func | output | 8 | Global pin-function byte |
| wdog_route | output | 1 | A general-purpose pin is routed to the watchdog output |
| bus_we | output | 1 | Register write strobe to the attached functions |
| bus_dev | output | 8 | Device number for the write |
| bus_reg | output | 8 | Register number for the write |
| bus_wdata | output | 8 | Data byte for the write |

## Verification
The hardest situation to reach is proving that a locked or out-of-range access has no effect. Such a write leaves nothing visible at the moment it happens. The bench therefore first fills every private register of every implemented device with a distinct pattern computed from the device and register numbers. It then writes junk to every unimplemented index on an implemented device and on a device number past the last one. Finally it reopens the port and reads all 255 selectable indices for every device number, including the out-of-range one, against an arithmetic model. For the locked case, the bench relocks the port, issues data and index writes, and walks the key sequence through an interrupted attempt. After reopening it reads back the still-latched index and the activate bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam logic [7:0] KEY_OPEN   = 8'h87;
   localparam logic [7:0] KEY_CLOSE  = 8'hAA;
   localparam logic [7:0] RX_LDN     = 8'h07;
   localparam logic [7:0] RX_PINF    = 8'h2C;
   localparam logic [7:0] RX_ACT     = 8'h30;
   localparam logic [7:0] RD_LOCKED  = 8'hFF;
   localparam int         PINF_ON_B  = 4;
   localparam int         PINF_OFF_B = 5;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_ARMED  = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;
endpackage

// File: rtl/cfgp_keylock.sv
module cfgp_keylock
   import cfgp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic       idx_load
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (idx_wr) begin
         unique case (state_q)
            KS_LOCKED: state_d = (wdata == KEY_OPEN)  ? KS_ARMED  : KS_LOCKED;
            KS_ARMED:  state_d = (wdata == KEY_OPEN)  ? KS_OPEN   : KS_LOCKED;
            KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
            default:   state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign open     = (state_q == KS_OPEN);
   assign idx_load = idx_wr && (state_q == KS_OPEN) && (wdata != KEY_CLOSE);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
   import cfgp_pkg::*;
#(
   parameter int         NUM_DEV = 9,
   parameter logic [7:0] PRIV_LO = 8'hE0,
   parameter logic [7:0] PRIV_HI = 8'hF4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         dev,
   input  logic [7:0]         regn,
   input  logic [7:0]         wdata,
   output logic [7:0]         rd_data,
   output logic [NUM_DEV-1:0] active
);
   localparam int PRIV_N = int'(PRIV_HI) - int'(PRIV_LO) + 1;
   localparam int PW     = (PRIV_N > 1) ? $clog2(PRIV_N) : 1;

   logic          hit_act, hit_priv;
   logic [PW-1:0] off;
   logic [7:0]    dev_rd [NUM_DEV];

   assign hit_act  = (regn == RX_ACT);
   assign hit_priv = (regn >= PRIV_LO) && (regn <= PRIV_HI);
   assign off      = PW'(regn - PRIV_LO);

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic       sel;
      logic       act_q;
      logic [7:0] mem [PRIV_N];

      assign sel = (dev == 8'(d));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q <= 1'b0;
            for (int k = 0; k < PRIV_N; k++) mem[k] <= 8'h00;
         end else if (wr_en && sel) begin
            if (hit_act)  act_q    <= wdata[0];
            if (hit_priv) mem[off] <= wdata;
         end
      end

      assign active[d] = act_q;

      always_comb begin
         dev_rd[d] = 8'h00;
         if (sel && hit_act)  dev_rd[d] = {7'b0, act_q};
         if (sel && hit_priv) dev_rd[d] = mem[off];
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int d = 0; d < NUM_DEV; d++) rd_data = rd_data | dev_rd[d];
   end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import cfgp_pkg::*;
#(
   parameter int         NUM_DEV = 9,
   parameter logic [7:0] PRIV_LO = 8'hE0,
   parameter logic [7:0] PRIV_HI = 8'hF4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_wr,
   input  logic               hst_rd,
   input  logic               hst_addr,
   input  logic [7:0]         hst_wdata,
   output logic [7:0]         hst_rdata,
   output logic               cfg_unlocked,
   output logic [NUM_DEV-1:0] dev_active,
   output logic [7:0]         pin_func,
   output logic               wdog_route,
   output logic               bus_we,
   output logic [7:0]         bus_dev,
   output logic [7:0]         bus_reg,
   output logic [7:0]         bus_wdata
);
   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_ndev
      $error("keyed_cfg_port: NUM_DEV must lie in 1..256");
   end
   if (PRIV_HI < PRIV_LO || PRIV_LO <= RX_ACT) begin : g_bad_win
      $error("keyed_cfg_port: private window must be non-empty and above the activate register");
   end

   logic       open, idx_load, idx_wr, dat_wr;
   logic [7:0] idx_q, ldn_q, pinf_q, bank_rd, reg_rd;

   assign idx_wr = hst_wr && !hst_addr;
   assign dat_wr = hst_wr &&  hst_addr && open;

   cfgp_keylock u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (hst_wdata),
      .open     (open),
      .idx_load (idx_load)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= 8'h00;
         ldn_q  <= 8'h00;
         pinf_q <= 8'h00;
      end else begin
         if (idx_load) idx_q <= hst_wdata;
         if (dat_wr && idx_q == RX_LDN)  ldn_q  <= hst_wdata;
         if (dat_wr && idx_q == RX_PINF) pinf_q <= hst_wdata;
      end
   end

   cfgp_bank #(
      .NUM_DEV (NUM_DEV),
      .PRIV_LO (PRIV_LO),
      .PRIV_HI (PRIV_HI)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dat_wr && idx_q >= RX_ACT),
      .dev     (ldn_q),
      .regn    (idx_q),
      .wdata   (hst_wdata),
      .rd_data (bank_rd),
      .active  (dev_active)
   );

   always_comb begin
      if (idx_q == RX_LDN)       reg_rd = ldn_q;
      else if (idx_q == RX_PINF) reg_rd = pinf_q;
      else if (idx_q >= RX_ACT)  reg_rd = bank_rd;
      else                       reg_rd = 8'h00;
   end

   always_comb begin
      if (!hst_rd)       hst_rdata = 8'h00;
      else if (!open)    hst_rdata = RD_LOCKED;
      else if (hst_addr) hst_rdata = reg_rd;
      else               hst_rdata = idx_q;
   end

   assign cfg_unlocked = open;
   assign pin_func     = pinf_q;
   assign wdog_route   = pinf_q[PINF_ON_B] && !pinf_q[PINF_OFF_B];
   assign bus_we       = dat_wr;
   assign bus_dev      = ldn_q;
   assign bus_reg      = idx_q;
   assign bus_wdata    = hst_wdata;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
   parameter int NUM_DEV = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hst_wr,
   input logic               hst_rd,
   input logic               hst_addr,
   input logic [7:0]         hst_wdata,
   input logic [7:0]         hst_rdata,
   input logic               cfg_unlocked,
   input logic [NUM_DEV-1:0] dev_active,
   input logic [7:0]         pin_func
);
   AST_OPEN_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_unlocked) |-> $past(hst_wr && !hst_addr && hst_wdata == 8'h87)); // R1

   AST_CLOSE_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_unlocked) |-> $past(hst_wr && !hst_addr && hst_wdata == 8'hAA)); // R3

   AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_unlocked) |-> $stable(dev_active)); // R3

   AST_PINF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_unlocked) |-> $stable(pin_func)); // R3

   AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && !cfg_unlocked) |-> hst_rdata == 8'hFF); // R4
endmodule

bind keyed_cfg_port cfgp_chk #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_wr       (hst_wr),
   .hst_rd       (hst_rd),
   .hst_addr     (hst_addr),
   .hst_wdata    (hst_wdata),
   .hst_rdata    (hst_rdata),
   .cfg_unlocked (cfg_unlocked),
   .dev_active   (dev_active),
   .pin_func     (pin_func)
);

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;
   localparam int ND = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hst_wr = 1'b0, hst_rd = 1'b0, hst_addr = 1'b0;
   logic [7:0]    hst_wdata = 8'h00;
   logic [7:0]    hst_rdata, pin_func, bus_dev, bus_reg, bus_wdata;
   logic          cfg_unlocked, wdog_route, bus_we;
   logic [ND-1:0] dev_active;

   int nchk = 0, nerr = 0;
   logic [7:0] pm [0:15][0:20];
   logic       act_m [0:15];
   logic [7:0] pinf_m = 8'h00;

   always #10 clk = ~clk;

   keyed_cfg_port #(.NUM_DEV(ND)) u0 (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .cfg_unlocked(cfg_unlocked), .dev_active(dev_active), .pin_func(pin_func),
      .wdog_route(wdog_route), .bus_we(bus_we), .bus_dev(bus_dev),
      .bus_reg(bus_reg), .bus_wdata(bus_wdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
      @(posedge clk);
      #1 hst_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      hst_addr = a; hst_rd = 1'b1;
      #2 v = hst_rdata;
      hst_rd = 1'b0;
   endtask

   task automatic setreg(input logic [7:0] i, input logic [7:0] v);
      wr(1'b0, i); wr(1'b1, v);
   endtask

   task automatic getreg(input logic [7:0] i, output logic [7:0] v);
      wr(1'b0, i); rd(1'b1, v);
   endtask

   function automatic logic impl(input int dev, input int idx);
      return idx == 8'h07 || idx == 8'h2C ||
             (dev < ND && (idx == 8'h30 || (idx >= 8'hE0 && idx <= 8'hF4)));
   endfunction

   function automatic logic [7:0] expv(input int dev, input int idx);
      if (idx == 8'h07) return 8'(dev);
      if (idx == 8'h2C) return pinf_m;
      if (dev < ND && idx == 8'h30) return {7'b0, act_m[dev]};
      if (dev < ND && idx >= 8'hE0 && idx <= 8'hF4) return pm[dev][idx - 8'hE0];
      return 8'h00;
   endfunction

   function automatic logic [ND-1:0] actv();
      logic [ND-1:0] r;
      for (int d = 0; d < ND; d++) r[d] = act_m[d];
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      for (int d = 0; d < 16; d++) begin
         act_m[d] = 1'b0;
         for (int k = 0; k < 21; k++) pm[d][k] = 8'h00;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11 reset state
      #1;
      chk("R11 locked", cfg_unlocked, 0);
      chk("R11 active", dev_active, 0);
      chk("R11 pinf", pin_func, 0);
      chk("R11 route", wdog_route, 0);
      rd(1'b0, v); chk("R4 locked index read", v, 8'hFF);
      rd(1'b1, v); chk("R4 locked data read", v, 8'hFF);

      // R1 two keys, data write between does not break the sequence
      wr(1'b0, 8'h87);
      chk("R1 one key", cfg_unlocked, 0);
      wr(1'b1, 8'h12);
      wr(1'b0, 8'h87);
      chk("R1 unlocked", cfg_unlocked, 1);
      getreg(8'h07, v); chk("R11 ldn zero", v, 0);

      // R5 index readback
      wr(1'b0, 8'h3C); rd(1'b0, v); chk("R5 index readback", v, 8'h3C);

      // R6 / R10 out-of-range device
      setreg(8'h07, 8'hA5); getreg(8'h07, v); chk("R6 ldn full byte", v, 8'hA5);
      setreg(8'h30, 8'h01); chk("R10 act on absent dev", dev_active, 0);
      rd(1'b1, v); chk("R10 absent act read", v, 0);

      // R8 read-modify-write, then sweep all values
      getreg(8'h2C, v);
      setreg(8'h2C, (v | 8'h10) & ~8'h20);
      chk("R8 route set", wdog_route, 1);
      chk("R8 pinf rmw", pin_func, 8'h10);
      for (int i = 0; i < 256; i++) begin
         wr(1'b1, 8'(i));
         #1;
         chk("R8 pinf", pin_func, i);
         chk("R8 route", wdog_route, 32'(i[4] & ~i[5]));
         rd(1'b1, v); chk("R8 readback", v, i);
      end
      wr(1'b1, 8'h10); pinf_m = 8'h10;

      // R7 activate bits
      setreg(8'h07, 8'd8); setreg(8'h30, 8'hFF); act_m[8] = 1'b1;
      chk("R7 dev8 on", dev_active, actv());
      rd(1'b1, v); chk("R7 readback bit0", v, 8'h01);
      setreg(8'h07, 8'd7); setreg(8'h30, 8'h01); act_m[7] = 1'b1;
      chk("R7 dev7 on", dev_active, actv());
      setreg(8'h07, 8'd8); setreg(8'h30, 8'hFE); act_m[8] = 1'b0;
      chk("R7 dev8 off", dev_active, actv());

      // R12 write bus
      setreg(8'h07, 8'd7); wr(1'b0, 8'hE3);
      @(negedge clk);
      hst_addr = 1'b1; hst_wdata = 8'h08; hst_wr = 1'b1;
      #1;
      chk("R12 we", bus_we, 1);
      chk("R12 dev", bus_dev, 7);
      chk("R12 reg", bus_reg, 8'hE3);
      chk("R12 data", bus_wdata, 8'h08);
      @(posedge clk); #1 hst_wr = 1'b0;
      pm[7][3] = 8'h08;
      @(negedge clk); hst_addr = 1'b0; hst_wdata = 8'hE3; hst_wr = 1'b1;
      #1 chk("R12 no we on index write", bus_we, 0);
      @(posedge clk); #1 hst_wr = 1'b0;

      // R9 fill private registers with a computed pattern
      for (int d = 0; d < ND; d++) begin
         setreg(8'h07, 8'(d));
         for (int k = 0; k < 21; k++) begin
            pm[d][k] = 8'((d * 37 + k * 5) ^ 8'h5A);
            setreg(8'(8'hE0 + k), pm[d][k]);
         end
      end

      // R10 junk writes to unimplemented registers
      for (int d = 3; d <= ND; d += ND - 3) begin
         setreg(8'h07, 8'(d));
         for (int i = 0; i < 256; i++)
            if (!impl(d, i) && i != 8'hAA) setreg(8'(i), 8'h5A);
      end
      chk("R10 active unchanged", dev_active, actv());

      // R9 / R10 sweep every selectable index of every device number
      for (int d = 0; d <= ND; d++) begin
         setreg(8'h07, 8'(d));
         for (int i = 0; i < 256; i++) begin
            if (i != 8'hAA) begin
               getreg(8'(i), v);
               chk("R9 R10 sweep", v, expv(d, i));
            end
         end
      end

      // R3 / R4 lock, then writes have no effect
      setreg(8'h07, 8'd8); wr(1'b0, 8'h30);
      wr(1'b0, 8'hAA);
      chk("R3 locked", cfg_unlocked, 0);
      rd(1'b0, v); chk("R4 index read locked", v, 8'hFF);
      rd(1'b1, v); chk("R4 data read locked", v, 8'hFF);
      @(negedge clk); hst_addr = 1'b1; hst_wdata = 8'h01; hst_wr = 1'b1;
      #1 chk("R4 no bus when locked", bus_we, 0);
      @(posedge clk); #1 hst_wr = 1'b0;
      chk("R3 active held", dev_active, actv());
      wr(1'b0, 8'h2C); wr(1'b1, 8'h00);
      chk("R3 pinf held", pin_func, pinf_m);

      // R2 interrupted key
      wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
      chk("R2 interrupted stays locked", cfg_unlocked, 0);
      wr(1'b0, 8'h87);
      chk("R2 back-to-back unlocks", cfg_unlocked, 1);
      rd(1'b0, v); chk("R3 index held through lock", v, 8'h30);
      rd(1'b1, v); chk("R3 act reg held", v, 8'h00);
      wr(1'b0, 8'h07); rd(1'b1, v); chk("R3 ldn held", v, 8'd8);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule